// File: doc/BRIEF.md
# Set/Clear Interrupt Request Controller

This block collects up to 32 interrupt sources and turns them into two CPU request lines and one wakeup line. Every per-source control bit lives in an array that software changes through a pair of addresses: writing ones to the set address turns the selected bits on, and writing ones to the clear address turns them off. Zero bits in the written word leave the other sources alone, so drivers never need a read-modify-write sequence. Two instances side by side cover 64 sources.

Each source takes its raw input from one of two pins, picked by a per-source select bit. A three-bit sensing code sets how that input is judged: active-high level, active-low level, latched rising edge, latched falling edge, or off. A pending source counts towards a request only when its mask bit is set. Its route bit picks which of the two request lines it drives. Software learns which source fired by reading one unmasked status word per request line and comparing it with the mask array. The block does no priority encoding or vectoring.

The design is a register bank, a per-source sensing slice and an output stage. It has no sequencer: each cycle the pending vector is worked out from the current inputs, the latched edges and the control arrays, and it is registered onto the outputs.

Top module: `irq_setclr_ctrl`

## Requirements
- R1: After reset every control array, both edge latches and the test word are zero, and cpu_req0, cpu_req1 and wake_o are low.
- R2: There are seven control arrays, indexed k = 0..6: sensing bit 0, sensing bit 1, sensing bit 2, route, input select, mask and wakeup. Array k has its set address at word address 2k and its clear address at 2k+1. A write to a set address ORs the data into the array. A write to a clear address clears the bits that are 1 in the data. All other bits keep their value.
- R3: Reading a set address returns the array's current value, and reading a clear address returns zero. The other addresses are: 14 rising-edge latch, 15 falling-edge latch, 16 status of request 0, 17 status of request 1, 18 test word.
- R4: The sensing code {bit2,bit1,bit0} = 101 makes a source pending while its selected input is 1.
- R5: The code 110 makes a source pending while its selected input is 0.
- R6: The code 001 latches a 0-to-1 change of the input and the code 010 latches a 1-to-0 change. The latch keeps the source pending after the input returns, until a 1 is written to that bit at address 14 (rising) or 15 (falling). A latched bit reads back as 1 at that address.
- R7: The code 000 and the unused codes 011, 100 and 111 never make a source pending, whatever its input does.
- R8: A source whose route bit is 1 belongs to request 0, and one whose route bit is 0 belongs to request 1. The status word at 16 equals pending AND route, and the word at 17 equals pending AND NOT route. Both are unaffected by the mask.
- R9: cpu_req0 (cpu_req1) is the OR over all sources of pending AND mask AND route (AND NOT route), registered once. A source with its mask bit at 0 never raises either request.
- R10: Clearing and then setting the mask bit of a source whose level input is still active lowers and then raises its request again. Each change shows one clock after the array write.
- R11: wake_o is the OR over all sources of pending AND wakeup enable, registered once, and it does not depend on the mask.
- R12: An input-select bit of 1 takes the source's input from dev_irq, and 0 takes it from pin_irq.
- R13: The test word at address 18 is written and read back whole and has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Word address |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| dev_irq | input | 32 | Peripheral interrupt inputs |
| pin_irq | input | 32 | External pin interrupt inputs |
| cpu_req0 | output | 1 | Request line 0 |
| cpu_req1 | output | 1 | Request line 1 |
| wake_o | output | 1 | Wakeup for idle exit |

## Verification
The bench runs every source through all eight sensing codes with the input held both low and high. After each run it drops the input back, which shows whether edge latches stay set and whether level modes release. A design that reversed the sensing bit order, dropped a latch on its own, or let an unused code pass would give the wrong request or status here. Pseudo-random route, mask and input words check that the OR-reduction goes to the right line and that a masked source stays silent. The mask toggle is sampled in the exact cycle to catch a request that is not registered or is not re-evaluated. The clear-address reads catch a bank that echoes the array instead of returning zero.

// File: rtl/irq_sc_pkg.sv
package irq_sc_pkg;

    localparam int ADDR_W = 5;
    localparam int N_ARR  = 7;

    // control array indices; array k owns set address 2k and clear address 2k+1
    localparam int ARR_SNS0 = 0;
    localparam int ARR_SNS1 = 1;
    localparam int ARR_SNS2 = 2;
    localparam int ARR_ROUTE = 3;
    localparam int ARR_INSEL = 4;
    localparam int ARR_MASK = 5;
    localparam int ARR_WAKE = 6;

    typedef enum logic [ADDR_W-1:0] {
        A_RISE_LAT = 5'd14,
        A_FALL_LAT = 5'd15,
        A_STAT0    = 5'd16,
        A_STAT1    = 5'd17,
        A_TEST     = 5'd18
    } misc_addr_e;

    // sensing code ordered {bit2, bit1, bit0}
    typedef enum logic [2:0] {
        SNS_OFF    = 3'b000,
        SNS_RISE   = 3'b001,
        SNS_FALL   = 3'b010,
        SNS_LVL_HI = 3'b101,
        SNS_LVL_LO = 3'b110
    } sense_e;

endpackage

// File: rtl/irq_sc_regs.sv
module irq_sc_regs
    import irq_sc_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [N_SRC-1:0]     wdata,
    output logic [N_SRC-1:0]     arr_o [N_ARR],
    output logic [N_SRC-1:0]     rise_clr_o,
    output logic [N_SRC-1:0]     fall_clr_o,
    output logic [N_SRC-1:0]     test_o
);

    for (genvar k = 0; k < N_ARR; k++) begin : g_arr
        localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(2 * k);
        localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(2 * k + 1);
        logic [N_SRC-1:0] bits_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bits_q <= '0;
            end else if (we && addr == SET_A) begin
                bits_q <= bits_q | wdata;
            end else if (we && addr == CLR_A) begin
                bits_q <= bits_q & ~wdata;
            end
        end

        assign arr_o[k] = bits_q;

        assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (we && addr == SET_A) |=> ((bits_q & $past(wdata)) == $past(wdata)));
        assert_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (we && addr == CLR_A) |=> ((bits_q & $past(wdata)) == '0));
    end

    assign rise_clr_o = (we && addr == A_RISE_LAT) ? wdata : '0;
    assign fall_clr_o = (we && addr == A_FALL_LAT) ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            test_o <= '0;
        end else if (we && addr == A_TEST) begin
            test_o <= wdata;
        end
    end

endmodule

// File: rtl/irq_sc_sense.sv
module irq_sc_sense
    import irq_sc_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] dev_irq,
    input  logic [N_SRC-1:0] pin_irq,
    input  logic [N_SRC-1:0] sns0,
    input  logic [N_SRC-1:0] sns1,
    input  logic [N_SRC-1:0] sns2,
    input  logic [N_SRC-1:0] insel,
    input  logic [N_SRC-1:0] rise_clr,
    input  logic [N_SRC-1:0] fall_clr,
    output logic [N_SRC-1:0] pend_o,
    output logic [N_SRC-1:0] rise_lat_o,
    output logic [N_SRC-1:0] fall_lat_o
);

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic   raw;
        logic   prev_q;
        logic   rise_q;
        logic   fall_q;
        logic   pend;
        sense_e mode;

        assign raw  = insel[i] ? dev_irq[i] : pin_irq[i];
        assign mode = sense_e'({sns2[i], sns1[i], sns0[i]});

        // a new edge in the clearing cycle wins so no event is lost
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                rise_q <= 1'b0;
                fall_q <= 1'b0;
            end else begin
                prev_q <= raw;
                rise_q <= ((mode == SNS_RISE) && raw && !prev_q) || (rise_q && !rise_clr[i]);
                fall_q <= ((mode == SNS_FALL) && !raw && prev_q) || (fall_q && !fall_clr[i]);
            end
        end

        always_comb begin
            unique case (mode)
                SNS_LVL_HI: pend = raw;
                SNS_LVL_LO: pend = !raw;
                SNS_RISE:   pend = rise_q;
                SNS_FALL:   pend = fall_q;
                default:    pend = 1'b0;
            endcase
        end

        assign pend_o[i]     = pend;
        assign rise_lat_o[i] = rise_q;
        assign fall_lat_o[i] = fall_q;
    end

    assert_rise_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(rise_lat_o) & ~$past(rise_clr)) & ~rise_lat_o) == '0);
    assert_fall_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(fall_lat_o) & ~$past(fall_clr)) & ~fall_lat_o) == '0);

endmodule

// File: rtl/irq_setclr_ctrl.sv
module irq_setclr_ctrl
    import irq_sc_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        bus_addr,
    input  logic              bus_we,
    input  logic [N_SRC-1:0]  bus_wdata,
    output logic [N_SRC-1:0]  bus_rdata,
    input  logic [N_SRC-1:0]  dev_irq,
    input  logic [N_SRC-1:0]  pin_irq,
    output logic              cpu_req0,
    output logic              cpu_req1,
    output logic              wake_o
);

    logic [N_SRC-1:0] arr [N_ARR];
    logic [N_SRC-1:0] rise_clr, fall_clr, test_w;
    logic [N_SRC-1:0] pend_w, rise_lat, fall_lat;
    logic [N_SRC-1:0] stat0, stat1;

    irq_sc_regs #(.N_SRC(N_SRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .arr_o(arr), .rise_clr_o(rise_clr), .fall_clr_o(fall_clr), .test_o(test_w)
    );

    irq_sc_sense #(.N_SRC(N_SRC)) u_sense (
        .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .pin_irq(pin_irq),
        .sns0(arr[ARR_SNS0]), .sns1(arr[ARR_SNS1]), .sns2(arr[ARR_SNS2]),
        .insel(arr[ARR_INSEL]), .rise_clr(rise_clr), .fall_clr(fall_clr),
        .pend_o(pend_w), .rise_lat_o(rise_lat), .fall_lat_o(fall_lat)
    );

    assign stat0 = pend_w & arr[ARR_ROUTE];
    assign stat1 = pend_w & ~arr[ARR_ROUTE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_req0 <= 1'b0;
            cpu_req1 <= 1'b0;
            wake_o   <= 1'b0;
        end else begin
            cpu_req0 <= |(stat0 & arr[ARR_MASK]);
            cpu_req1 <= |(stat1 & arr[ARR_MASK]);
            wake_o   <= |(pend_w & arr[ARR_WAKE]);
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < N_ARR; k++) begin
            if (bus_addr == ADDR_W'(2 * k)) bus_rdata = arr[k];
        end
        unique case (bus_addr)
            A_RISE_LAT: bus_rdata = rise_lat;
            A_FALL_LAT: bus_rdata = fall_lat;
            A_STAT0:    bus_rdata = stat0;
            A_STAT1:    bus_rdata = stat1;
            A_TEST:     bus_rdata = test_w;
            default:    ;
        endcase
    end

    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (arr[ARR_MASK] == '0) |=> !(cpu_req0 || cpu_req1));
    assert_wake_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(pend_w != '0));

endmodule

// File: tb/sim_irq_setclr_ctrl.sv
`timescale 1ns/1ps
module sim_irq_setclr_ctrl;

    localparam logic [4:0] SNS0_S = 0, SNS0_C = 1, ROUTE_S = 6, ROUTE_C = 7,
                           INSEL_S = 8, INSEL_C = 9, MASK_S = 10, MASK_C = 11,
                           WAKE_S = 12, WAKE_C = 13, RISE = 14, FALL = 15,
                           ST0 = 16, ST1 = 17, TST = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] dev_irq = '0;
    logic [31:0] pin_irq = '0;
    logic        cpu_req0, cpu_req1, wake_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    irq_setclr_ctrl #(.N_SRC(32)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_irq(dev_irq),
        .pin_irq(pin_irq), .cpu_req0(cpu_req0), .cpu_req1(cpu_req1), .wake_o(wake_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // sensing code {bit2,bit1,bit0} lives at set/clear pairs 0/1, 2/3, 4/5
    task automatic set_code(input logic [31:0] m, input logic [2:0] c);
        for (int b = 0; b < 3; b++) wr(c[b] ? 5'(2 * b) : 5'(2 * b + 1), m);
    endtask

    function automatic logic pend_on(input int c, input int lv);
        case (c)
            5: return lv[0];
            6: return !lv[0];
            1: return lv[0];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic pend_off(input int c, input int lv);
        case (c)
            6: return 1'b1;
            1, 2: return lv[0];
            default: return 1'b0;
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] d, seed, rt, mk, wk;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R1 reset state, R3 all addresses read zero
        chk("R1 req0", {31'b0, cpu_req0}, 0);
        chk("R1 req1", {31'b0, cpu_req1}, 0);
        chk("R1 wake", {31'b0, wake_o}, 0);
        for (int a = 0; a < 19; a++) begin
            rd(5'(a), d);
            chk("R1 reset read", d, 0);
        end

        // R2/R3 set and clear on every array
        for (int k = 0; k < 7; k++) begin
            wr(5'(2 * k), 32'hA5A5_0F0F);
            rd(5'(2 * k), d);     chk("R2 set", d, 32'hA5A5_0F0F);
            rd(5'(2 * k + 1), d); chk("R3 clear addr reads zero", d, 0);
            wr(5'(2 * k), 32'h0000_F000);
            rd(5'(2 * k), d);     chk("R2 set keeps others", d, 32'hA5A5_FF0F);
            wr(5'(2 * k + 1), 32'h0F00_00FF);
            rd(5'(2 * k), d);     chk("R2 clear keeps others", d, 32'hA0A5_FF00);
            wr(5'(2 * k + 1), 32'hFFFF_FFFF);
            rd(5'(2 * k), d);     chk("R2 clear all", d, 0);
        end

        // sweep: every source, every code, both levels (R4 R5 R6 R7 R8 R11)
        wr(ROUTE_S, 32'hAAAA_AAAA);
        wr(INSEL_S, 32'hFFFF_FFFF);
        wr(MASK_S, 32'hFFFF_FFFF);
        wr(WAKE_S, 32'hFFFF_FFFF);
        for (int i = 0; i < 32; i++) begin
            for (int c = 0; c < 8; c++) begin
                for (int lv = 0; lv < 2; lv++) begin
                    logic odd, p;
                    odd = i[0];
                    set_code(32'(1) << i, 3'(c));
                    dev_irq = lv[0] ? (32'(1) << i) : 32'h0;
                    wait_n(2);
                    p = pend_on(c, lv);
                    chk("R4 R5 R6 R7 req0 input on", {31'b0, cpu_req0}, {31'b0, p & odd});
                    chk("R8 req1 input on", {31'b0, cpu_req1}, {31'b0, p & !odd});
                    chk("R11 wake input on", {31'b0, wake_o}, {31'b0, p});
                    rd(ST0, d);
                    chk("R8 status0", d, (p && odd) ? (32'(1) << i) : 32'h0);
                    dev_irq = 32'h0;
                    wait_n(2);
                    p = pend_off(c, lv);
                    chk("R6 R7 req0 input off", {31'b0, cpu_req0}, {31'b0, p & odd});
                    chk("R6 R7 req1 input off", {31'b0, cpu_req1}, {31'b0, p & !odd});
                    if ((c == 1 || c == 2) && lv == 1) begin
                        rd(c == 1 ? RISE : FALL, d);
                        chk("R6 latch readback", d, 32'(1) << i);
                    end
                    wr(RISE, 32'hFFFF_FFFF);
                    wr(FALL, 32'hFFFF_FFFF);
                    set_code(32'(1) << i, 3'd0);
                    wait_n(2);
                    chk("R6 cleared req0", {31'b0, cpu_req0}, 0);
                    chk("R6 cleared req1", {31'b0, cpu_req1}, 0);
                end
            end
        end

        // R8 R9 R11 wide patterns, all sources active-high level
        set_code(32'hFFFF_FFFF, 3'b101);
        seed = 32'h1357_9BDF;
        for (int n = 0; n < 40; n++) begin
            seed = seed * 32'd1103515245 + 32'd12345; rt = seed;
            seed = seed * 32'd1103515245 + 32'd12345; mk = seed & (n < 4 ? 32'h0 : 32'hFFFF_FFFF);
            seed = seed * 32'd1103515245 + 32'd12345; wk = seed & 32'h0F0F_F0F0;
            wr(ROUTE_C, 32'hFFFF_FFFF); wr(ROUTE_S, rt);
            wr(MASK_C, 32'hFFFF_FFFF);  wr(MASK_S, mk);
            wr(WAKE_C, 32'hFFFF_FFFF);  wr(WAKE_S, wk);
            seed = seed * 32'd1103515245 + 32'd12345;
            dev_irq = seed & (n[0] ? 32'h0001_0081 : 32'hFFFF_FFFF);
            wait_n(2);
            chk("R9 req0 pattern", {31'b0, cpu_req0}, {31'b0, |(dev_irq & mk & rt)});
            chk("R9 req1 pattern", {31'b0, cpu_req1}, {31'b0, |(dev_irq & mk & ~rt)});
            chk("R11 wake pattern", {31'b0, wake_o}, {31'b0, |(dev_irq & wk)});
            rd(ST0, d); chk("R8 status0 pattern", d, dev_irq & rt);
            rd(ST1, d); chk("R8 status1 pattern", d, dev_irq & ~rt);
        end

        // R12 input select
        dev_irq = 32'hFFFF_FFFF; pin_irq = 32'h0;
        wr(ROUTE_S, 32'hFFFF_FFFF); wr(MASK_S, 32'hFFFF_FFFF); wr(WAKE_C, 32'hFFFF_FFFF);
        wr(INSEL_C, 32'hFFFF_FFFF);
        wait_n(2);
        rd(ST0, d); chk("R12 pin path idle", d, 0);
        chk("R12 req0 idle", {31'b0, cpu_req0}, 0);
        pin_irq = 32'h0000_0020;
        wait_n(2);
        rd(ST0, d); chk("R12 pin path active", d, 32'h0000_0020);
        chk("R12 req0 from pin", {31'b0, cpu_req0}, 1);

        // R10 mask clear then set, exact cycle
        pin_irq = 32'h0;
        wr(INSEL_S, 32'hFFFF_FFFF);
        dev_irq = 32'h0000_0200;
        wait_n(2);
        chk("R10 req0 before", {31'b0, cpu_req0}, 1);
        wr(MASK_C, 32'h0000_0200);
        chk("R10 req0 registered", {31'b0, cpu_req0}, 1);
        wait_n(1);
        chk("R10 req0 masked", {31'b0, cpu_req0}, 0);
        wr(MASK_S, 32'h0000_0200);
        chk("R10 req0 still low", {31'b0, cpu_req0}, 0);
        wait_n(1);
        chk("R10 req0 reraised", {31'b0, cpu_req0}, 1);

        // R11 wake independent of mask, R9 masked silent
        wr(MASK_C, 32'hFFFF_FFFF);
        wr(WAKE_S, 32'h0000_0200);
        wait_n(2);
        chk("R9 req0 masked", {31'b0, cpu_req0}, 0);
        chk("R11 wake while masked", {31'b0, wake_o}, 1);

        // R13 test word
        wr(TST, 32'h1234_5678);
        rd(TST, d); chk("R13 test readback", d, 32'h1234_5678);
        wait_n(2);
        chk("R13 req0 unchanged", {31'b0, cpu_req0}, 0);
        chk("R13 wake unchanged", {31'b0, wake_o}, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule